// File: doc/BRIEF.md
# Parallel-Comparison Logic Self-Test Harness

This block runs an exhaustive self-test over a set of identical combinational logic blocks. A binary counter walks through every value of the shared input word, one new value per clock. All blocks under test receive the same word in parallel. Their responses come back on one wide bus and are grouped, at most four blocks per group. A response analyzer for each group checks that every member agrees with the group's first member. Because the blocks are identical and a fault is unlikely to hit all of them the same way, this agreement stands in for a stored expected response.

Each analyzer keeps a sticky error flag. Once a disagreement is seen, the analyzer stops evaluating, and nothing clears the flag until the next start. The analyzer registers the responses one stage behind the counter. Each comparison therefore belongs to the pattern that caused it, and the final pattern is judged before completion is signalled. A start pulse from an idle harness launches a run. A one-cycle done pulse marks the end, and fail reports whether any group saw a disagreement.

Top module: `bist_cmp_harness`

## Requirements
- R1: After reset, busy_o, done_o and fail_o are low, grp_err_o is all zeros and pattern_o is zero.
- R2: After start_i is accepted at a clock edge, pattern_o is 0 in the following cycle and increases by one every cycle up to 2^PAT_W-1, with no value skipped or repeated.
- R3: busy_o is high from the cycle after the accepting edge until the cycle after the last pattern has been applied. done_o is then high for exactly one cycle, and its first high cycle comes 2^PAT_W+1 clock edges after the accepting edge.
- R4: Block b of group g drives bits [(g*BUTS_PER_GROUP+b)*RESP_W +: RESP_W] of but_resp_i. Bit g of grp_err_o is set if, for any applied pattern, the response of any block in group g differs from that of block 0 of the same group.
- R5: A set group error bit stays set while later patterns agree, through the done cycle and afterwards, until the next accepted start.
- R6: A disagreement that occurs only on the first pattern, or only on the terminal pattern, is still flagged by the time done_o is high.
- R7: fail_o equals the OR of grp_err_o while done_o is high and is low in every other cycle.
- R8: start_i is ignored while busy_o is high. The pattern sequence and the done timing of the run in progress do not change.
- R9: An accepted start clears every group error bit, so grp_err_o is zero in the cycle after the accepting edge.
- R10: Group error bits are independent: a disagreement inside one group never sets another group's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Run request, accepted when busy_o is low |
| pattern_o | output | PAT_W | Shared input word driven to every block under test |
| but_resp_i | input | N_GROUPS*BUTS_PER_GROUP*RESP_W | Concatenated responses of all blocks under test |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Any group disagreed; meaningful only with done_o |
| grp_err_o | output | N_GROUPS | Sticky per-group disagreement flags |

## Verification
The hardest situation to reach is a disagreement that is confined to a single pattern at an edge of the sequence: the first one, or the terminal one just before the harness stops. These cases show whether the analyzer stage lines up with the counter, and whether the last comparison is taken before done. The bench models the blocks under test as a shared function with a fault that can be placed on any block. The fault can be a stuck-at on one output bit over all patterns, or an inversion on one chosen pattern. The table places one-pattern inversions on pattern 0, on the terminal pattern and on a mid-run pattern, which covers both the edges and stickiness.

// File: rtl/bist_harness_pkg.sv
// Shared definitions for the parallel-comparison self-test harness.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bist_harness_pkg;

    // Upper bound on blocks one response analyzer may compare.
    localparam int unsigned MAX_BUTS_PER_GROUP = 4;

    // Phases of one self-test run.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_APPLY = 2'd1,
        PH_DRAIN = 2'd2,
        PH_DONE  = 2'd3
    } run_phase_e;

endpackage

// File: rtl/bist_pat_counter.sv
// Exhaustive pattern source: a plain binary counter that restarts from zero
// on clear_i and advances by one per clock while adv_i is high, stopping at
// its all-ones terminal value.
// Assumes: clear_i and adv_i are never high in the same cycle.
module bist_pat_counter #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         adv_i,
    output logic [W-1:0] value_o,
    output logic         at_max_o
);

    logic [W-1:0] cnt_q;

    // Terminal value detection.
    assign at_max_o = &cnt_q;
    assign value_o  = cnt_q;

    // Counter register: clear, then advance until terminal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (adv_i && !at_max_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: every advance moves exactly one step
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !at_max_o && !clear_i) |=> (value_o == W'($past(value_o) + 1'b1)));

    // R2: a clear always lands on pattern zero
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (value_o == '0));

endmodule

// File: rtl/bist_group_ora.sv
// Response analyzer for one group of identical blocks. It registers the
// group's responses one stage behind the pattern source. Each registered
// response is compared with that of block 0. A disagreement sets a sticky
// error flag, and once the flag is set the analyzer stops evaluating.
// Assumes: 2 <= GS <= MAX_BUTS_PER_GROUP; valid_i marks cycles carrying a pattern.
module bist_group_ora
    import bist_harness_pkg::*;
#(
    parameter int unsigned GS = 4,
    parameter int unsigned OW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           valid_i,
    input  logic [GS*OW-1:0] resp_i,
    output logic           err_o
);

    localparam int unsigned STAGE_W = GS * OW;

    logic [STAGE_W-1:0] stage_q;
    logic               stage_v_q;
    logic               err_q;
    logic [GS-1:0]      differs;
    logic               mismatch;

    // Per-member disagreement with block 0 of the group.
    for (genvar b = 0; b < GS; b++) begin : g_member
        if (b == 0) begin : g_ref
            assign differs[b] = 1'b0;
        end else begin : g_cmp
            assign differs[b] = (stage_q[b*OW +: OW] != stage_q[0 +: OW]);
        end
    end

    assign mismatch = |differs;
    assign err_o    = err_q;

    // Response stage: aligns each comparison with its own pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q   <= '0;
            stage_v_q <= 1'b0;
        end else if (clear_i) begin
            stage_v_q <= 1'b0;
        end else begin
            stage_q   <= resp_i;
            stage_v_q <= valid_i;
        end
    end

    // Sticky error flag; evaluation stops once it is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (clear_i) begin
            err_q <= 1'b0;
        end else if (!err_q && stage_v_q && mismatch) begin
            err_q <= 1'b1;
        end
    end

    // R4: group size within analyzer capacity
    initial begin
        assert_group_size_R4: assert (GS >= 2 && GS <= MAX_BUTS_PER_GROUP);
    end

    // R5: a set flag holds until the next clear
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clear_i) |=> err_q);

    // R4: a flag only rises from a valid registered comparison
    assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(stage_v_q));

endmodule

// File: rtl/bist_cmp_harness.sv
// Top of the parallel-comparison self-test harness. A run phase machine
// sequences apply, drain and done. The counter drives one shared pattern
// to all blocks under test, and one analyzer per group judges agreement
// one cycle later.
// Assumes: blocks under test are combinational, so but_resp_i reflects
// pattern_o in the same cycle.
module bist_cmp_harness
    import bist_harness_pkg::*;
#(
    parameter int unsigned PAT_W          = 18,
    parameter int unsigned RESP_W         = 4,
    parameter int unsigned N_GROUPS       = 2,
    parameter int unsigned BUTS_PER_GROUP = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      start_i,
    output logic [PAT_W-1:0]                          pattern_o,
    input  logic [N_GROUPS*BUTS_PER_GROUP*RESP_W-1:0] but_resp_i,
    output logic                                      busy_o,
    output logic                                      done_o,
    output logic                                      fail_o,
    output logic [N_GROUPS-1:0]                       grp_err_o
);

    localparam int unsigned GROUP_BITS = BUTS_PER_GROUP * RESP_W;

    run_phase_e phase_q;
    logic       accept;
    logic       applying;
    logic       at_max;

    assign applying = (phase_q == PH_APPLY);
    assign busy_o   = (phase_q == PH_APPLY) || (phase_q == PH_DRAIN);
    assign done_o   = (phase_q == PH_DONE);
    assign accept   = start_i && !busy_o;
    assign fail_o   = done_o && (|grp_err_o);

    // Run sequencing: apply all patterns, drain the analyzer stage, flag done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:  phase_q <= accept ? PH_APPLY : PH_IDLE;
                PH_APPLY: phase_q <= at_max ? PH_DRAIN : PH_APPLY;
                PH_DRAIN: phase_q <= PH_DONE;
                PH_DONE:  phase_q <= accept ? PH_APPLY : PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    bist_pat_counter #(
        .W (PAT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .adv_i    (applying),
        .value_o  (pattern_o),
        .at_max_o (at_max)
    );

    // One analyzer per comparison group.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        bist_group_ora #(
            .GS (BUTS_PER_GROUP),
            .OW (RESP_W)
        ) u_ora (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (accept),
            .valid_i (applying),
            .resp_i  (but_resp_i[g*GROUP_BITS +: GROUP_BITS]),
            .err_o   (grp_err_o[g])
        );
    end

    // R3: done is a single-cycle pulse
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: the end of busy is always marked by done
    assert_busy_ends_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8: a start during a run does not restart the counter
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (applying && start_i && !at_max) |=> (pattern_o != '0));

    // R9: an accepted start clears every group flag
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (grp_err_o == '0));

endmodule

// File: tb/bist_cmp_harness_tb_top.sv
// Self-checking bench: combinational stand-ins for the blocks under test,
// with one injectable fault, walked through a scenario table and then
// directed tests.
module bist_cmp_harness_tb_top;

    localparam int PW   = 6;
    localparam int RW   = 4;
    localparam int NG   = 2;
    localparam int GS   = 4;
    localparam int NB   = NG * GS;
    localparam int NPAT = 1 << PW;

    // Fault kinds: 0 stuck-at-0, 1 stuck-at-1, 2 invert. pat -1 means every pattern.
    typedef struct packed {
        int         but;
        int         bitn;
        int         kind;
        int         pat;
        logic [1:0] exp;
    } scen_t;

    localparam int NSCEN = 7;
    localparam scen_t SCEN [NSCEN] = '{
        '{-1, 0, 0, -1, 2'b00},   // fault-free: no flags
        '{ 1, 0, 1, -1, 2'b01},   // stuck-at-1 in group 0
        '{ 5, 2, 0, -1, 2'b10},   // stuck-at-0 in group 1
        '{ 0, 3, 2, 63, 2'b01},   // reference block, terminal pattern only
        '{ 7, 1, 2,  0, 2'b10},   // first pattern only
        '{ 2, 0, 2, 30, 2'b01},   // mid-run single pattern: must stick
        '{ 4, 3, 1, -1, 2'b10}    // reference block of group 1
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [PW-1:0]     pattern_o;
    logic [NB*RW-1:0]  but_resp_i;
    logic              busy_o, done_o, fail_o;
    logic [NG-1:0]     grp_err_o;

    int f_but  = -1;
    int f_bit  = 0;
    int f_kind = 0;
    int f_pat  = -1;
    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    bist_cmp_harness #(
        .PAT_W          (PW),
        .RESP_W         (RW),
        .N_GROUPS       (NG),
        .BUTS_PER_GROUP (GS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .pattern_o  (pattern_o),
        .but_resp_i (but_resp_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .grp_err_o  (grp_err_o)
    );

    function automatic logic [RW-1:0] good_fn(logic [PW-1:0] p);
        return p[3:0] ^ {p[5:4], p[5:4]};
    endfunction

    // Stand-in blocks under test with the configured fault.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            logic [RW-1:0] r;
            r = good_fn(pattern_o);
            if (b == f_but && (f_pat < 0 || f_pat == int'(pattern_o))) begin
                case (f_kind)
                    0:       r[f_bit] = 1'b0;
                    1:       r[f_bit] = 1'b1;
                    default: r[f_bit] = ~r[f_bit];
                endcase
            end
            but_resp_i[b*RW +: RW] = r;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full run; poke_at >= 0 raises start_i during that pattern's cycle.
    task automatic run_check(input logic [NG-1:0] exp_err, input int poke_at);
        int bad = 0;
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        chk("R9 flags cleared after start", 32'(grp_err_o), 32'd0);
        chk("R3 busy after start", 32'(busy_o), 32'd1);
        for (int k = 0; k < NPAT; k++) begin
            if (pattern_o !== PW'(k)) bad++;
            if (busy_o !== 1'b1 || done_o !== 1'b0 || fail_o !== 1'b0) bad++;
            if (k == poke_at) start_i = 1'b1;
            @(posedge clk); #1 start_i = 1'b0;
        end
        chk("R2/R8/R7 pattern sequence and run outputs", 32'(bad), 32'd0);
        chk("R3 drain cycle busy", 32'(busy_o), 32'd1);
        chk("R3 drain cycle no done", 32'(done_o), 32'd0);
        @(posedge clk); #1;
        chk("R3 done high", 32'(done_o), 32'd1);
        chk("R3 busy low at done", 32'(busy_o), 32'd0);
        chk("R4/R6/R10 group flags at done", 32'(grp_err_o), 32'(exp_err));
        chk("R7 fail at done", 32'(fail_o), 32'(|exp_err));
        @(posedge clk); #1;
        chk("R3 done single cycle", 32'(done_o), 32'd0);
        chk("R7 fail low after done", 32'(fail_o), 32'd0);
        chk("R5 flags held after done", 32'(grp_err_o), 32'(exp_err));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 busy after reset", 32'(busy_o), 32'd0);
        chk("R1 done after reset", 32'(done_o), 32'd0);
        chk("R1 fail after reset", 32'(fail_o), 32'd0);
        chk("R1 flags after reset", 32'(grp_err_o), 32'd0);
        chk("R1 pattern after reset", 32'(pattern_o), 32'd0);
        rst_n = 1'b1;

        // Scenario table: R4, R5, R6, R10.
        for (int s = 0; s < NSCEN; s++) begin
            f_but  = SCEN[s].but;
            f_bit  = SCEN[s].bitn;
            f_kind = SCEN[s].kind;
            f_pat  = SCEN[s].pat;
            run_check(SCEN[s].exp, -1);
        end

        // R8: start raised mid-run on a fault-free run is ignored.
        f_but = -1;
        run_check(2'b00, 10);

        // R9: faulty run leaves flags set; next start clears them.
        f_but = 6; f_bit = 1; f_kind = 1; f_pat = -1;
        run_check(2'b10, -1);
        @(posedge clk); #1;
        chk("R5 flags held while idle", 32'(grp_err_o), 32'b10);
        f_but = -1;
        run_check(2'b00, -1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule